// File: doc/BRIEF.md
# Buffered Countdown Timer Channel

This block is one channel of a multi-channel countdown timer. Software writes a count buffer and a compare buffer, and a share of a common control word. The live down-counter only takes a new value when the channel's manual-update bit goes from 0 to 1. While the start bit is set, each tick strobe lowers the counter by one. A tick that arrives with the counter already at zero is an expiry. It raises a one-cycle `expire` pulse. Then either the counter reloads from the count buffer, or the channel stops and hardware clears its own start bit.

The `CH_IDX` parameter sets where the channel's fields sit in the shared control word. The highest-numbered channel is a narrow variant. It has no invert bit and no compare buffer, and its auto-reload bit moves down into the slot the invert bit would use. The live counter is always visible on `cnt_live`. Prescaling and waveform generation are outside this block.

Top module: `cdt_channel`

## Requirements
- R1: After a synchronous active-low reset, `cnt_live`, `cnt_buf_q`, `cmp_buf_q` and `ctrl_q` are 0, and `expire` and `out_inv` are low.
- R2: Writes use select codes 0 (count buffer), 1 (compare buffer) and 2 (control word). Writing the count buffer leaves `cnt_live` unchanged. A control write that raises the manual-update bit from 0 to 1 copies the count buffer into `cnt_live` at that clock edge.
- R3: A control write that keeps the manual-update bit at 1 does not reload `cnt_live`.
- R4: When `tick` is high and the start bit is set, `cnt_live` falls by one per clock. While the start bit is clear, ticks leave it unchanged.
- R5: Clearing the start bit stops counting, and `cnt_live` holds its value.
- R6: A tick with `cnt_live` at 0, start set and auto-reload set gives `expire` high for the following cycle. `cnt_live` takes the count buffer value and the start bit stays set.
- R7: A tick with `cnt_live` at 0, start set and auto-reload clear gives the `expire` pulse and clears the start bit in `ctrl_q`. `cnt_live` stays 0 and later ticks give no pulse.
- R8: Control field positions: channel 0 uses bits [3:0]. Channel n>0 starts at bit 4n+4. Within a field the order is start, manual-update, invert, auto-reload. Control bits outside the channel's own field read back 0 and have no effect. `out_inv` follows the invert bit.
- R9: On the last channel (index 4 by default), bits 20, 21 and 22 are start, manual-update and auto-reload. It has no invert bit, so `out_inv` stays 0. It has no compare buffer, so `cmp_buf_q` reads 0 and compare writes are ignored.
- R10: A single control write that raises both manual-update and start loads the count buffer first. The next tick decrements from that loaded value.
- R11: A write with select code 3 changes no buffer, no control bit and no counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count strobe for this channel |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 count buffer, 1 compare buffer, 2 control word, 3 none |
| wr_data | input | DATA_W | Write data; control writes carry the full shared word |
| cnt_live | output | CNT_W | Live down-counter value |
| cnt_buf_q | output | CNT_W | Count buffer |
| cmp_buf_q | output | CNT_W | Compare buffer (0 on the narrow channel) |
| ctrl_q | output | DATA_W | This channel's control bits at their positions, all other bits 0 |
| expire | output | 1 | One-cycle pulse after an expiry |
| out_inv | output | 1 | Invert bit level |

## Verification
The hardest state to reach is the expiry itself. The counter has to be primed through the buffer and a manual-update edge, then started with a separate write, then ticked down exactly to zero. Only after that can one more tick land with the auto-reload bit in a known state. The stimulus does this with small buffer values such as 2 and 1, so each expiry is a few ticks away. It then checks the cycle after expiry for the pulse, the reloaded or held counter, and the state of the start bit. The same path is repeated on a narrow-channel instance, where the auto-reload bit sits at a different position.

// File: rtl/cdt_pkg.sv
// Package: shared types and field-position arithmetic for the countdown
// timer channel. Assumes the narrow channel is the highest index.
package cdt_pkg;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic start;
        logic upd;
        logic inv;
        logic reload;
    } ctrl_bits_t;

    // First bit of a channel's field in the shared control word.
    function automatic int fld_base(input int ch);
        return (ch == 0) ? 0 : (4 * ch + 4);
    endfunction

    function automatic int pos_start(input int ch);
        return fld_base(ch);
    endfunction

    function automatic int pos_upd(input int ch);
        return fld_base(ch) + 1;
    endfunction

    function automatic int pos_inv(input int ch);
        return fld_base(ch) + 2;
    endfunction

    // The narrow channel shifts its reload bit into the unused invert slot.
    function automatic int pos_reload(input int ch, input int narrow_ch);
        return (ch == narrow_ch) ? fld_base(ch) + 2 : fld_base(ch) + 3;
    endfunction

    function automatic bit is_full(input int ch, input int narrow_ch);
        return ch != narrow_ch;
    endfunction

endpackage

// File: rtl/cdt_ctrl.sv
// Control field of one channel: extracts this channel's bits from a write
// of the shared control word, detects the manual-update rising edge, and
// lets the counter clear the start bit on a non-reloading expiry.
// Assumes field positions fit inside DATA_W. A control write that coincides
// with a hardware stop wins over it.
module cdt_ctrl
    import cdt_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int NUM_CH = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hw_stop,
    output ctrl_bits_t        bits_q,
    output logic              load_req,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int  NARROW  = NUM_CH - 1;
    localparam int  P_START = pos_start(CH_IDX);
    localparam int  P_UPD   = pos_upd(CH_IDX);
    localparam int  P_INV   = pos_inv(CH_IDX);
    localparam int  P_RLD   = pos_reload(CH_IDX, NARROW);
    localparam bit  HAS_INV = is_full(CH_IDX, NARROW);

    logic start_q, upd_q, inv_q, reload_q;

    // Rising edge of manual-update inside a control write.
    assign load_req = wr_ctrl && wr_data[P_UPD] && !upd_q;

    // Start bit: set or cleared by writes, cleared by hardware on a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= 1'b0;
        else if (wr_ctrl)  start_q <= wr_data[P_START];
        else if (hw_stop)  start_q <= 1'b0;
    end

    // Manual-update and auto-reload levels, as last written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q    <= 1'b0;
            reload_q <= 1'b0;
        end else if (wr_ctrl) begin
            upd_q    <= wr_data[P_UPD];
            reload_q <= wr_data[P_RLD];
        end
    end

    generate
        if (HAS_INV) begin : g_inv
            // Invert bit exists only on full channels.
            always_ff @(posedge clk) begin
                if (!rst_n)       inv_q <= 1'b0;
                else if (wr_ctrl) inv_q <= wr_data[P_INV];
            end
        end else begin : g_no_inv
            assign inv_q = 1'b0;
        end
    endgenerate

    assign bits_q.start  = start_q;
    assign bits_q.upd    = upd_q;
    assign bits_q.inv    = inv_q;
    assign bits_q.reload = reload_q;

    // Place the channel's bits at their positions for readback.
    always_comb begin
        ctrl_word         = '0;
        ctrl_word[P_START] = start_q;
        ctrl_word[P_UPD]   = upd_q;
        ctrl_word[P_RLD]   = reload_q;
        if (HAS_INV) ctrl_word[P_INV] = inv_q;
    end

    // R7: a hardware stop with no competing write leaves start clear.
    a_r7_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stop && !wr_ctrl) |=> !start_q);

endmodule

// File: rtl/cdt_bufs.sv
// Count and compare buffers. The compare buffer is built only when
// HAS_CMP is set; otherwise it reads as zero and writes are dropped.
module cdt_bufs #(
    parameter int  CNT_W   = 32,
    parameter bit  HAS_CMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q
);
    // Count buffer holds the next load/reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wr_val;
    end

    generate
        if (HAS_CMP) begin : g_cmp
            // Compare buffer, stored for a downstream waveform stage.
            always_ff @(posedge clk) begin
                if (!rst_n)      cmp_q <= '0;
                else if (wr_cmp) cmp_q <= wr_val;
            end
        end else begin : g_no_cmp
            assign cmp_q = '0;
        end
    endgenerate

endmodule

// File: rtl/cdt_counter.sv
// Live down-counter. A load request wins over a tick in the same cycle.
// A tick while running decrements; at zero it expires, then reloads or
// requests a stop. The expire pulse is registered.
module cdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             hw_stop
);
    logic step, at_zero, fire;

    assign step    = tick && run && !load;
    assign at_zero = (count == '0);
    assign fire    = step && at_zero;
    assign hw_stop = fire && !reload_en;

    // Counter update: load, reload on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (load)             count <= buf_val;
        else if (fire && reload_en) count <= buf_val;
        else if (step && !at_zero) count <= count - 1'b1;
    end

    // One-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) expire <= 1'b0;
        else        expire <= fire;
    end

    // R2: a load places the buffer value in the counter.
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(buf_val)));
    // R4: a running tick above zero lowers the count by one.
    a_r4_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !load && count != '0) |=> (count == $past(count) - 1'b1));
    // R5: with no load and no running tick the counter holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(tick && run)) |=> $stable(count));
    // R6: reloading expiry takes the buffer value.
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !load && count == '0 && reload_en) |=> (count == $past(buf_val) && expire));

endmodule

// File: rtl/cdt_channel.sv
// Top of one buffered countdown timer channel: decodes writes, and ties
// the control field, the buffers and the live counter together.
// Assumes CNT_W <= DATA_W and that the control fields fit in DATA_W.
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int NUM_CH = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_live,
    output logic [CNT_W-1:0]  cnt_buf_q,
    output logic [CNT_W-1:0]  cmp_buf_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              expire,
    output logic              out_inv
);
    localparam bit HAS_CMP = is_full(CH_IDX, NUM_CH - 1);

    wsel_e      sel;
    logic       wr_cnt, wr_cmp, wr_ctrl;
    logic       load_req, hw_stop;
    ctrl_bits_t bits;

    // Write decode.
    assign sel     = wsel_e'(wr_sel);
    assign wr_cnt  = wr_en && (sel == SEL_CNT);
    assign wr_cmp  = wr_en && (sel == SEL_CMP);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);

    cdt_ctrl #(
        .CH_IDX (CH_IDX),
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .hw_stop   (hw_stop),
        .bits_q    (bits),
        .load_req  (load_req),
        .ctrl_word (ctrl_q)
    );

    cdt_bufs #(
        .CNT_W   (CNT_W),
        .HAS_CMP (HAS_CMP)
    ) u_bufs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cnt (wr_cnt),
        .wr_cmp (wr_cmp),
        .wr_val (wr_data[CNT_W-1:0]),
        .cnt_q  (cnt_buf_q),
        .cmp_q  (cmp_buf_q)
    );

    cdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (bits.start),
        .load      (load_req),
        .reload_en (bits.reload),
        .buf_val   (cnt_buf_q),
        .count     (cnt_live),
        .expire    (expire),
        .hw_stop   (hw_stop)
    );

    assign out_inv = bits.inv;

    // R1: nothing expires in the cycle right after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!expire && cnt_live == '0));
    // R11: a write with the unused select code leaves the buffers alone.
    a_r11_no_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(cnt_buf_q) && $stable(cmp_buf_q)));

endmodule

// File: tb/cdt_channel_tb.sv
// Scoreboard bench: the driver pushes expected values; a monitor pops
// and compares them 2 ns after each rising edge.
module cdt_channel_tb;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         tk0 = 0, we0 = 0, tk4 = 0, we4 = 0;
    logic [1:0]   sl0 = 0, sl4 = 0;
    logic [W-1:0] wd0 = 0, wd4 = 0;
    logic [W-1:0] live0, buf0, cmp0, ctl0, live4, buf4, cmp4, ctl4;
    logic         exp0, inv0, exp4, inv4;

    cdt_channel #(.CH_IDX(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tk0), .wr_en(we0), .wr_sel(sl0),
        .wr_data(wd0), .cnt_live(live0), .cnt_buf_q(buf0), .cmp_buf_q(cmp0),
        .ctrl_q(ctl0), .expire(exp0), .out_inv(inv0));

    cdt_channel #(.CH_IDX(4)) u_dut_c4 (
        .clk(clk), .rst_n(rst_n), .tick(tk4), .wr_en(we4), .wr_sel(sl4),
        .wr_data(wd4), .cnt_live(live4), .cnt_buf_q(buf4), .cmp_buf_q(cmp4),
        .ctrl_q(ctl4), .expire(exp4), .out_inv(inv4));

    typedef struct {
        int           inst;
        int           sig;
        logic [W-1:0] val;
        string        req;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Signal ids: 0 live, 1 count buf, 2 compare buf, 3 ctrl, 4 expire, 5 invert.
    function automatic logic [W-1:0] probe(int inst, int sig);
        case (sig)
            0: return inst == 0 ? live0 : live4;
            1: return inst == 0 ? buf0 : buf4;
            2: return inst == 0 ? cmp0 : cmp4;
            3: return inst == 0 ? ctl0 : ctl4;
            4: return W'(inst == 0 ? exp0 : exp4);
            default: return W'(inst == 0 ? inv0 : inv4);
        endcase
    endfunction

    task automatic expect_v(int inst, int sig, logic [W-1:0] v, string req);
        item_t it;
        it.inst = inst; it.sig = sig; it.val = v; it.req = req;
        q.push_back(it);
    endtask

    task automatic drive(int inst, bit we, logic [1:0] sl, logic [W-1:0] d, bit tk);
        if (inst == 0) begin we0 = we; sl0 = sl; wd0 = d; tk0 = tk; end
        else           begin we4 = we; sl4 = sl; wd4 = d; tk4 = tk; end
    endtask

    task automatic go();
        @(negedge clk);
        we0 = 0; tk0 = 0; sl0 = 0; wd0 = 0;
        we4 = 0; tk4 = 0; sl4 = 0; wd4 = 0;
    endtask

    // Monitor: compare every pending expectation after the edge.
    initial forever begin
        @(posedge clk);
        #2;
        while (q.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it  = q.pop_front();
            act = probe(it.inst, it.sig);
            n_vec++;
            if (act !== it.val) begin
                n_bad++;
                $display("FAIL %s inst%0d sig%0d actual=%h expected=%h",
                         it.req, it.inst, it.sig, act, it.val);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        go();
        // R1: reset state on both instances.
        for (int i = 0; i < 2; i++) begin
            int inst = (i == 0) ? 0 : 4;
            for (int s = 0; s < 6; s++) expect_v(inst, s, '0, "R1");
        end
        go();
        rst_n = 1'b1;
        go();

        // Channel 0: fields start=bit0, upd=bit1, inv=bit2, reload=bit3.
        drive(0, 1, 2'd0, 5, 0); expect_v(0, 1, 5, "R2"); expect_v(0, 0, 0, "R2"); go();
        drive(0, 1, 2'd1, 7, 0); expect_v(0, 2, 7, "R2"); go();
        drive(0, 1, 2'd2, 32'h2, 0); expect_v(0, 0, 5, "R2"); expect_v(0, 3, 32'h2, "R8"); go();
        drive(0, 1, 2'd0, 9, 0); expect_v(0, 0, 5, "R2"); expect_v(0, 1, 9, "R2"); go();
        drive(0, 1, 2'd2, 32'h2, 0); expect_v(0, 0, 5, "R3"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 5, "R4"); go();
        drive(0, 1, 2'd2, 32'h1, 0); expect_v(0, 3, 32'h1, "R8"); expect_v(0, 0, 5, "R4"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 4, "R4"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 3, "R4"); go();
        expect_v(0, 0, 3, "R4"); go();
        drive(0, 1, 2'd2, 32'h0, 0); expect_v(0, 0, 3, "R5"); expect_v(0, 3, 0, "R5"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 3, "R5"); go();
        drive(0, 1, 2'd2, 32'h1, 0); go();
        for (int k = 2; k >= 0; k--) begin
            drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, W'(k), "R4"); expect_v(0, 4, 0, "R7"); go();
        end
        drive(0, 0, 2'd0, 0, 1);
        expect_v(0, 0, 0, "R7"); expect_v(0, 4, 1, "R7"); expect_v(0, 3, 0, "R7"); go();
        expect_v(0, 4, 0, "R7"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 0, "R7"); expect_v(0, 4, 0, "R7"); go();

        // R6: auto-reload expiry.
        drive(0, 1, 2'd0, 2, 0); go();
        drive(0, 1, 2'd2, 32'hA, 0); expect_v(0, 0, 2, "R6"); expect_v(0, 3, 32'hA, "R8"); go();
        drive(0, 1, 2'd2, 32'h9, 0); expect_v(0, 3, 32'h9, "R6"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 1, "R6"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 0, "R6"); expect_v(0, 4, 0, "R6"); go();
        drive(0, 0, 2'd0, 0, 1);
        expect_v(0, 0, 2, "R6"); expect_v(0, 4, 1, "R6"); expect_v(0, 3, 32'h9, "R6"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 1, "R6"); expect_v(0, 4, 0, "R6"); go();
        drive(0, 1, 2'd2, 32'h8, 0); expect_v(0, 0, 1, "R5"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 1, "R5"); go();

        // R10: update and start in one write.
        drive(0, 1, 2'd0, 6, 0); go();
        drive(0, 1, 2'd2, 32'h3, 0); expect_v(0, 0, 6, "R10"); expect_v(0, 3, 32'h3, "R10"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 5, "R10"); go();

        // R8: only the channel's own bits take effect; invert drives out_inv.
        drive(0, 1, 2'd2, 32'hFFFF_FFF4, 0);
        expect_v(0, 3, 32'h4, "R8"); expect_v(0, 5, 1, "R8"); expect_v(0, 0, 5, "R8"); go();
        drive(0, 0, 2'd0, 0, 1); expect_v(0, 0, 5, "R8"); go();

        // R11: select code 3 touches nothing.
        drive(0, 1, 2'd3, 32'h1234, 0);
        expect_v(0, 1, 6, "R11"); expect_v(0, 2, 7, "R11");
        expect_v(0, 3, 32'h4, "R11"); expect_v(0, 0, 5, "R11"); go();

        // Channel 4: start=bit20, upd=bit21, reload=bit22, no invert, no compare.
        drive(4, 1, 2'd1, 32'h55, 0); expect_v(4, 2, 0, "R9"); go();
        drive(4, 1, 2'd0, 1, 0); expect_v(4, 1, 1, "R9"); go();
        drive(4, 1, 2'd2, 32'h00E0_000F, 0);
        expect_v(4, 3, 32'h0060_0000, "R9"); expect_v(4, 0, 1, "R9"); expect_v(4, 5, 0, "R9"); go();
        drive(4, 1, 2'd2, 32'h0050_0000, 0); expect_v(4, 3, 32'h0050_0000, "R9"); go();
        drive(4, 0, 2'd0, 0, 1); expect_v(4, 0, 0, "R9"); go();
        drive(4, 0, 2'd0, 0, 1);
        expect_v(4, 0, 1, "R9"); expect_v(4, 4, 1, "R9"); expect_v(4, 3, 32'h0050_0000, "R9"); go();
        drive(4, 1, 2'd2, 32'h0010_0000, 0); go();
        drive(4, 0, 2'd0, 0, 1); expect_v(4, 0, 0, "R9"); go();
        drive(4, 0, 2'd0, 0, 1);
        expect_v(4, 0, 0, "R9"); expect_v(4, 4, 1, "R9"); expect_v(4, 3, 0, "R9"); go();

        go();
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule